// File: doc/BRIEF.md
# Level-Triggered Element FIFO with Sticky Error Flags

This block is the data queue that sits between a serial shifter and a register port in a synchronous serial peripheral. One parameter picks its personality. As a transmit queue, software writes elements in and the shifter drains them. As a receive queue, the shifter fills it and software reads it out. Elements are 4 to 16 bits wide, and the depth is a power of two.

A trigger output compares the stored-entry count with a programmed level, and the comparison runs in opposite directions for the two personalities. In transmit mode the trigger asks for more data. In receive mode it asks for data to be taken away. A DMA engine or an interrupt handler can act on it. Two live status bits summarise fill state, and the entry count is available at the port. Two sticky flags record a write that was refused and a read that found nothing; software clears them by writing ones. A synchronous clear input empties the queue.

Top module: `trig_fifo`

## Requirements
- R1: With `IS_RX`=0, `trig` is 1 exactly when `count` is strictly below `trig_level`.
- R2: With `IS_RX`=1, `trig` is 1 exactly when `count` is strictly above `trig_level`.
- R3: A `push` while the queue holds `DEPTH` entries is discarded. The count and the stored elements stay as they were, and sticky bit 0 (overflow) is 1 after the next clock edge.
- R4: A `pop` while the queue is empty leaves `count` at 0 and sets sticky bit 1 (underflow) at the next edge. While the queue is empty, `pop_data` is all ones with `IS_RX`=1 and all zeros with `IS_RX`=0.
- R5: `stat_live` with `IS_RX`=0 is {empty, not_full}. With `IS_RX`=1 it is {full, not_empty}, where bit 1 is the first field named and bit 0 the second.
- R6: Elements leave in the order they arrived. `count` equals accepted pushes minus accepted pops and updates at the edge that accepts them. `pop_data` shows the oldest element combinationally, and it is removed by the edge at which `pop` is high.
- R7: When `clr` is high at an edge, `count` and `sticky` are 0 after that edge, and a `push` or `pop` in that cycle has no effect.
- R8: A 1 in a bit of `sticky_clr` clears that sticky bit at the next edge. A 0 leaves the bit unchanged.
- R9: If a sticky bit is set by an event in the same cycle that `sticky_clr` clears it, the bit ends up 1.
- R10: `irq` is 1 exactly when some sticky bit is 1 and the matching bit of `int_en` is 1. It follows `int_en` in the same cycle.
- R11: After reset, `count` is 0 and `sticky` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of the contents and the sticky flags |
| push | input | 1 | Write request |
| push_data | input | DATA_W | Element to write |
| pop | input | 1 | Read request |
| pop_data | output | DATA_W | Oldest element, or the empty value |
| trig_level | input | AW+1 | Trigger threshold |
| sticky_clr | input | 2 | Write-one-to-clear mask for the sticky flags |
| int_en | input | 2 | Interrupt enable for each sticky flag |
| count | output | AW+1 | Stored entries |
| trig | output | 1 | Level trigger |
| stat_live | output | 2 | Live fill status (see R5) |
| sticky | output | 2 | Bit 0 overflow, bit 1 underflow |
| irq | output | 1 | Masked OR of the sticky flags |

## Verification
Four results come from combinational logic and are checked in the same cycle as their cause, with no clock edge between: `pop_data`, `trig`, `stat_live` and `irq`. `count` and `sticky` are registered, so they are due one edge after the stimulus. Inputs change on the falling edge. Each check samples on the following falling edge, which puts exactly one rising edge between cause and effect. Set-versus-clear collisions and a clear arriving together with a push are driven as single-cycle events, and the result is read on the very next falling edge.

// File: rtl/trig_fifo_pkg.sv
package trig_fifo_pkg;

  localparam int unsigned ST_W   = 2;
  localparam int unsigned ST_OVF = 0;
  localparam int unsigned ST_UDF = 1;

  // threshold compare: receive side fires above the level, transmit side below
  function automatic logic trig_eval(input logic is_rx,
                                     input logic [31:0] cnt,
                                     input logic [31:0] lvl);
    return is_rx ? (cnt > lvl) : (cnt < lvl);
  endfunction

  // sticky update: clear command wins, then new events win over w1c
  function automatic logic [ST_W-1:0] sticky_next(input logic [ST_W-1:0] cur,
                                                  input logic [ST_W-1:0] set,
                                                  input logic [ST_W-1:0] w1c,
                                                  input logic            clr);
    return clr ? '0 : ((cur & ~w1c) | set);
  endfunction

endpackage

// File: rtl/trig_fifo_store.sv
module trig_fifo_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] head,
  output logic [CW-1:0]     count,
  output logic              full,
  output logic              empty
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CW-1:0]     wr_ptr;
  logic [CW-1:0]     rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + CW'(1);
      if (rd_en) rd_ptr <= rd_ptr + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr[AW-1:0]] <= wr_data;
  end

  assign count = wr_ptr - rd_ptr;
  assign full  = (count == CW'(DEPTH));
  assign empty = (wr_ptr == rd_ptr);
  assign head  = mem[rd_ptr[AW-1:0]];

endmodule

// File: rtl/trig_fifo_flags.sv
module trig_fifo_flags
  import trig_fifo_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic [ST_W-1:0] set,
  input  logic [ST_W-1:0] w1c,
  input  logic [ST_W-1:0] int_en,
  output logic [ST_W-1:0] sticky,
  output logic            irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky <= '0;
    else        sticky <= sticky_next(sticky, set, w1c, clr);
  end

  assign irq = |(sticky & int_en);

endmodule

// File: rtl/trig_fifo.sv
module trig_fifo
  import trig_fifo_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8,
  parameter bit          IS_RX  = 1'b0,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  input  logic [CW-1:0]     trig_level,
  input  logic [ST_W-1:0]   sticky_clr,
  input  logic [ST_W-1:0]   int_en,
  output logic [CW-1:0]     count,
  output logic              trig,
  output logic [1:0]        stat_live,
  output logic [ST_W-1:0]   sticky,
  output logic              irq
);

  localparam logic [DATA_W-1:0] NO_DATA = '1;

  logic [DATA_W-1:0] head;
  logic              full;
  logic              empty;

  // named events for the checker
  logic ev_push_ok, ev_push_drop, ev_pop_ok, ev_pop_miss;
  logic [ST_W-1:0] ev_set;

  assign ev_push_ok   = push & ~full  & ~clr;
  assign ev_push_drop = push &  full  & ~clr;
  assign ev_pop_ok    = pop  & ~empty & ~clr;
  assign ev_pop_miss  = pop  &  empty & ~clr;

  always_comb begin
    ev_set         = '0;
    ev_set[ST_OVF] = ev_push_drop;
    ev_set[ST_UDF] = ev_pop_miss;
  end

  trig_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .wr_en   (ev_push_ok),
    .rd_en   (ev_pop_ok),
    .wr_data (push_data),
    .head    (head),
    .count   (count),
    .full    (full),
    .empty   (empty)
  );

  trig_fifo_flags u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .set    (ev_set),
    .w1c    (sticky_clr),
    .int_en (int_en),
    .sticky (sticky),
    .irq    (irq)
  );

  assign trig = trig_eval(IS_RX, 32'(count), 32'(trig_level));

  generate
    if (IS_RX) begin : g_rx
      assign stat_live = {full, ~empty};
      assign pop_data  = empty ? NO_DATA : head;
    end else begin : g_tx
      assign stat_live = {empty, ~full};
      assign pop_data  = empty ? '0 : head;
    end
  endgenerate

endmodule

// File: rtl/trig_fifo_chk.sv
module trig_fifo_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8,
  parameter bit          IS_RX  = 1'b0,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = AW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          push,
  input logic          pop,
  input logic          full,
  input logic          empty,
  input logic [CW-1:0] count,
  input logic [1:0]    sticky,
  input logic [1:0]    sticky_clr,
  input logic [1:0]    int_en,
  input logic          irq
);

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R6

  AST_DROP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && push && full && !pop) |=> count == $past(count)); // R3

  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && push && full) |=> sticky[0]); // R3

  AST_MISS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && pop && empty) |=> (sticky[1] && count == '0)); // R4

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0 && sticky == 2'b00)); // R7

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && sticky[0] && !sticky_clr[0]) |=> sticky[0]); // R8

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((sticky & int_en) == 2'b00) |-> !irq); // R10

  wire unused_ok = IS_RX ^ (DATA_W == 0);

endmodule

bind trig_fifo trig_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IS_RX(IS_RX)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr        (clr),
  .push       (push),
  .pop        (pop),
  .full       (full),
  .empty      (empty),
  .count      (count),
  .sticky     (sticky),
  .sticky_clr (sticky_clr),
  .int_en     (int_en),
  .irq        (irq)
);

// File: tb/test_trig_fifo.sv
`timescale 1ns/1ps
module test_trig_fifo;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       clr = 0, t_push = 0, t_pop = 0, r_push = 0, r_pop = 0;
  logic [7:0] pd = '0;
  logic [3:0] lvl = '0;
  logic [1:0] wc = '0, ie = '0;

  logic [7:0] t_pdata, r_pdata;
  logic [3:0] t_cnt, r_cnt;
  logic       t_trig, r_trig, t_irq, r_irq;
  logic [1:0] t_live, r_live, t_st, r_st;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  trig_fifo #(.DATA_W(8), .DEPTH(8), .IS_RX(1'b0)) i_trig_fifo (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push(t_push), .push_data(pd),
    .pop(t_pop), .pop_data(t_pdata), .trig_level(lvl), .sticky_clr(wc),
    .int_en(ie), .count(t_cnt), .trig(t_trig), .stat_live(t_live),
    .sticky(t_st), .irq(t_irq));

  trig_fifo #(.DATA_W(8), .DEPTH(8), .IS_RX(1'b1)) i_trig_fifo_rx (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push(r_push), .push_data(pd),
    .pop(r_pop), .pop_data(r_pdata), .trig_level(lvl), .sticky_clr(wc),
    .int_en(ie), .count(r_cnt), .trig(r_trig), .stat_live(r_live),
    .sticky(r_st), .irq(r_irq));

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push_t(input logic [7:0] v);
    pd = v; t_push = 1; cyc(); t_push = 0;
  endtask

  task automatic push_r(input logic [7:0] v);
    pd = v; r_push = 1; cyc(); r_push = 0;
  endtask

  task automatic t_reset();
    chk("R11 tx count", t_cnt, 0);
    chk("R11 tx sticky", t_st, 0);
    chk("R11 rx sticky", r_st, 0);
    chk("R5 tx live empty", t_live, 2'b11);
    chk("R5 rx live empty", r_live, 2'b00);
    chk("R10 rx irq idle", r_irq, 0);
  endtask

  task automatic t_tx_trigger_order();
    lvl = 4'd4;
    for (int i = 0; i < 3; i++) push_t(8'hA1 + 8'(i));
    chk("R6 tx count 3", t_cnt, 3);
    chk("R1 tx trig below level", t_trig, 1);
    push_t(8'hA4);
    chk("R1 tx trig at level", t_trig, 0);
    chk("R5 tx live partial", t_live, 2'b01);
    for (int i = 0; i < 4; i++) begin
      chk("R6 tx order", t_pdata, 8'hA1 + 8'(i));
      t_pop = 1; cyc(); t_pop = 0;
    end
    chk("R6 tx drained", t_cnt, 0);
  endtask

  task automatic t_rx_fill_overflow();
    lvl = 4'd2;
    push_r(8'h10); push_r(8'h11);
    chk("R2 rx trig at level", r_trig, 0);
    push_r(8'h12);
    chk("R2 rx trig above level", r_trig, 1);
    for (int i = 3; i < 8; i++) push_r(8'h10 + 8'(i));
    chk("R5 rx live full", r_live, 2'b11);
    push_r(8'hEE);
    chk("R3 rx count held", r_cnt, 8);
    chk("R3 rx overflow flag", r_st, 2'b01);
    for (int i = 0; i < 8; i++) begin
      chk("R3 rx contents kept", r_pdata, 8'h10 + 8'(i));
      r_pop = 1; cyc(); r_pop = 0;
    end
  endtask

  task automatic t_rx_underflow();
    chk("R4 rx sentinel", r_pdata, 8'hFF);
    r_pop = 1; cyc(); r_pop = 0;
    chk("R4 rx underflow flag", r_st, 2'b11);
    chk("R4 rx count zero", r_cnt, 0);
  endtask

  task automatic t_w1c();
    wc = 2'b01; cyc(); wc = 2'b00;
    chk("R8 w1c one bit", r_st, 2'b10);
  endtask

  task automatic t_irq_mask();
    ie = 2'b01; #1;
    chk("R10 irq masked", r_irq, 0);
    ie = 2'b10; #1;
    chk("R10 irq enabled", r_irq, 1);
    ie = 2'b00; cyc();
  endtask

  task automatic t_set_wins();
    wc = 2'b10; r_pop = 1; cyc(); wc = 2'b00; r_pop = 0;
    chk("R9 set beats clear", r_st, 2'b10);
    wc = 2'b10; cyc(); wc = 2'b00;
    chk("R8 w1c clears", r_st, 2'b00);
  endtask

  task automatic t_tx_underflow();
    chk("R4 tx empty value", t_pdata, 8'h00);
    t_pop = 1; cyc(); t_pop = 0;
    chk("R4 tx underflow flag", t_st, 2'b10);
  endtask

  task automatic t_clear();
    push_t(8'h55); push_t(8'h66);
    pd = 8'h77; t_push = 1; clr = 1; cyc(); t_push = 0; clr = 0;
    chk("R7 clr count", t_cnt, 0);
    chk("R7 clr sticky", t_st, 0);
    chk("R7 clr live", t_live, 2'b11);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    t_reset();
    t_tx_trigger_order();
    t_rx_fill_overflow();
    t_rx_underflow();
    t_w1c();
    t_irq_mask();
    t_set_wins();
    t_tx_underflow();
    t_clear();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule